// File: doc/BRIEF.md
# Compare-Match Timer Channel

A single 16-bit counting channel for periodic events, pulse generation and edge timestamping. An up-counter advances on ticks taken from a programmable division of the system clock. Each tick comes from a chosen edge (rising, falling or both) of the divided clock. One general register is compared against the counter. In compare mode a match can clear the counter, which gives a period of (general + 1) ticks, and can clear, set or toggle an output pin. In capture mode an edge on the input pin copies the counter into the general register.

Counting runs only while the `run` input is high. This input is one bit of a start register shared by several channels and kept outside the block. While `run` is low, the divider phase is held at zero. Software stops the channel, programs the clear source, the division, the general register and the counter, then raises `run`. A match or capture event and a counter wrap each set a status flag. A flag clears only after a status read that saw it set, followed by a write of 0 to that bit. The interrupt line combines the flags with their enables.

The register file sits on a simple synchronous bus. Read data is combinational from the address. Reads of the 8-bit registers appear in bits 7:0 with the upper bits zero.

Top module: `tmr_channel`

## Requirements
- R1: After synchronous reset every register reads 0, `cmp_out` is 0 and `irq` is 0.
- R2: While `run` is 0 the counter keeps its value unless it is written, and the divider phase is held at 0. The first clock edge with `run` high is therefore edge e=0 of the tick schedule.
- R3: The mode register (address 0) holds the division in bits 2:0 (0 = /1, 1 = /4, 2 = /16, 3 = /64) and the edge in bits 4:3 (0 rising, 1 falling, 2 or 3 both). With /1 the counter ticks on every running edge. With /N, rising ticks fall on edges where e mod N = N/2-1 and falling ticks where e mod N = N-1. Division codes 4 to 7 produce no ticks.
- R4: Mode bits 7:5 select the clear source. With code 1, a tick on which the counter equals the general register loads 0 instead of incrementing. Codes 0 and 2 to 7 never clear the counter.
- R5: With pin code (address 1, bits 3:0) 0 to 7, a tick on which the counter equals the general register sets the event flag (status bit 0).
- R6: A tick that moves the counter from 0xFFFF to 0 sets the wrap flag (status bit 4).
- R7: Writing pin code 1, 2 or 3 drives `cmp_out` to 0 from the next cycle. Codes 5, 6 or 7 drive it to 1. Codes 0 and 4 leave it unchanged.
- R8: On a compare match, the low two bits of the pin code act on `cmp_out`: 1 clears, 2 sets, 3 toggles, 0 keeps.
- R9: Pin code 8 captures on a rising `cap_in` edge, 9 on a falling edge, 10 or 11 on either edge. If `cap_in` changes before clock edge k, the general register holds the counter value from before edge k+2 after edge k+2, and status bit 0 sets. Edges of the other polarity, and codes 12 to 15, capture nothing.
- R10: A status flag clears only when a write to status (address 3) has a 0 in its bit, and an earlier `bus_rd` of status saw that flag at 1. Writing a 1 leaves the flag unchanged, and so does writing 0 without that read.
- R11: `irq` is high exactly when (status bit 0 and enable bit 0) or (status bit 4 and enable bit 4). The enable register is at address 2 and keeps only bits 0 and 4.
- R12: The counter (address 4) and the general register (address 5) are written as whole 16-bit words. A bus write wins over a tick or a capture in the same cycle, and the mode and pin registers read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | This channel's bit of the shared start register |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cap_in | input | 1 | Capture input pin |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts ticks for each division and edge choice over run lengths that end just before or just after a tick. A divider whose phase is off by one, or that is not reset on stop, then gives a different count. It checks the match-clear period and that clear codes other than 1 let the counter run past the general register. It also checks the wrap from 0xFFFF, which a design that missed it would leave without a flag. Flag clearing is tried with a write of 0 without the read, and with a write of 1 after the read, both of which must leave the flag set. The capture checks sample the general register one cycle before and on the expected capture cycle. They also apply an edge of the wrong polarity, which a wrong edge decoder would capture.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PHASE_W = 6;   // enough for the largest division (/64)
    localparam int NFLAG   = 2;   // event flag and wrap flag

    localparam logic [2:0] ADR_MODE = 3'd0;
    localparam logic [2:0] ADR_PIN  = 3'd1;
    localparam logic [2:0] ADR_IEN  = 3'd2;
    localparam logic [2:0] ADR_STAT = 3'd3;
    localparam logic [2:0] ADR_CNT  = 3'd4;
    localparam logic [2:0] ADR_GEN  = 3'd5;

    localparam logic [2:0] CLR_ON_MATCH = 3'd1;

    typedef struct packed {
        logic [2:0] clr_src;
        logic [1:0] edge_sel;
        logic [2:0] div_sel;
    } mode_t;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    function automatic logic is_compare(input logic [3:0] code);
        return !code[3];
    endfunction

    function automatic logic is_capture(input logic [3:0] code);
        return code[3:2] == 2'b10;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] div_sel,
    input  logic [1:0] edge_sel,
    output logic       tick
);
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] mask;
    logic [PHASE_W-1:0] part;
    logic               rise_pt;
    logic               fall_pt;

    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else             phase <= phase + 1'b1;
    end

    always_comb begin
        case (div_sel)
            3'd1:    mask = PHASE_W'(3);
            3'd2:    mask = PHASE_W'(15);
            3'd3:    mask = PHASE_W'(63);
            default: mask = '0;
        endcase
        part    = phase & mask;
        rise_pt = (part == (mask >> 1));
        fall_pt = (part == mask);
        tick    = 1'b0;
        if (run) begin
            if (div_sel == 3'd0) tick = 1'b1;
            else if (!div_sel[2]) begin
                case (edge_sel)
                    2'd0:    tick = rise_pt;
                    2'd1:    tick = fall_pt;
                    default: tick = rise_pt || fall_pt;
                endcase
            end
        end
    end

    // R2
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);
    // R3
    reserved_div_chk: assert property (@(posedge clk) disable iff (rst)
        div_sel[2] |-> !tick);

endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] io_code,
    input  logic       io_wr,
    input  logic [3:0] io_new,
    input  logic       match,
    input  logic       cap_in,
    output logic       pin_out,
    output logic       cap_evt
);
    logic     sync1, sync2, prev;
    pin_act_e act;

    assign act = pin_act_e'(io_code[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= cap_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    always_comb begin
        cap_evt = 1'b0;
        if (is_capture(io_code)) begin
            case (io_code[1:0])
                2'd0:    cap_evt = sync2 && !prev;
                2'd1:    cap_evt = !sync2 && prev;
                default: cap_evt = sync2 ^ prev;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_out <= 1'b0;
        end else if (io_wr) begin
            if (io_new[3:2] == 2'b00 && io_new[1:0] != 2'd0)      pin_out <= 1'b0;
            else if (io_new[3:2] == 2'b01 && io_new[1:0] != 2'd0) pin_out <= 1'b1;
        end else if (match && is_compare(io_code)) begin
            case (act)
                ACT_LOW:    pin_out <= 1'b0;
                ACT_HIGH:   pin_out <= 1'b1;
                ACT_TOGGLE: pin_out <= !pin_out;
                default:    pin_out <= pin_out;
            endcase
        end
    end

    // R7
    preset_high_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_new[3:2] == 2'b01 && io_new[1:0] != 2'd0) |=> pin_out);

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_req,
    input  logic             stat_rd,
    input  logic             stat_wr,
    input  logic [NFLAG-1:0] wbits,
    input  logic [NFLAG-1:0] enables,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    logic [NFLAG-1:0] armed;

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[gi] <= 1'b0;
                armed[gi] <= 1'b0;
            end else begin
                if (set_req[gi]) begin
                    flags[gi] <= 1'b1;
                end else if (stat_wr && !wbits[gi] && armed[gi]) begin
                    flags[gi] <= 1'b0;
                    armed[gi] <= 1'b0;
                end
                if (stat_rd && flags[gi]) armed[gi] <= 1'b1;
            end
        end

        // R10
        write_one_keeps_chk: assert property (@(posedge clk) disable iff (rst)
            (stat_wr && wbits[gi] && !set_req[gi]) |=> (flags[gi] == $past(flags[gi])));
        // R10
        unarmed_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
            (flags[gi] && !armed[gi] && !stat_rd) |=> flags[gi]);
    end

    assign irq = |(flags & enables);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             cap_in,
    output logic             cmp_out,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    mode_t             mode;
    logic [7:0]        pin_reg;
    logic [7:0]        ien;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  gen;
    logic              tick, match, clr_hit, cap_evt;
    logic              cnt_wr, gen_wr, pin_wr;
    logic [NFLAG-1:0]  flags;
    logic [NFLAG-1:0]  set_req;

    assign cnt_wr  = bus_wr && bus_addr == ADR_CNT;
    assign gen_wr  = bus_wr && bus_addr == ADR_GEN;
    assign pin_wr  = bus_wr && bus_addr == ADR_PIN;
    assign match   = tick && cnt == gen && is_compare(pin_reg[3:0]);
    assign clr_hit = match && mode.clr_src == CLR_ON_MATCH;
    assign set_req = {tick && !clr_hit && cnt == CNT_MAX, match || cap_evt};

    tmr_prescale u_pre (
        .clk(clk), .rst(rst), .run(run),
        .div_sel(mode.div_sel), .edge_sel(mode.edge_sel), .tick(tick)
    );

    tmr_pin u_pin (
        .clk(clk), .rst(rst), .io_code(pin_reg[3:0]), .io_wr(pin_wr),
        .io_new(bus_wdata[3:0]), .match(match), .cap_in(cap_in),
        .pin_out(cmp_out), .cap_evt(cap_evt)
    );

    tmr_flags u_flags (
        .clk(clk), .rst(rst), .set_req(set_req),
        .stat_rd(bus_rd && bus_addr == ADR_STAT),
        .stat_wr(bus_wr && bus_addr == ADR_STAT),
        .wbits({bus_wdata[4], bus_wdata[0]}),
        .enables({ien[4], ien[0]}),
        .flags(flags), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= '0;
            pin_reg <= '0;
            ien     <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADR_MODE: mode    <= mode_t'(bus_wdata[7:0]);
                ADR_PIN:  pin_reg <= bus_wdata[7:0];
                ADR_IEN:  ien     <= bus_wdata[7:0] & 8'h11;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (cnt_wr)  cnt <= bus_wdata;
        else if (clr_hit) cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          gen <= '0;
        else if (gen_wr)  gen <= bus_wdata;
        else if (cap_evt) gen <= cnt;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_MODE: bus_rdata[7:0] = mode;
            ADR_PIN:  bus_rdata[7:0] = pin_reg;
            ADR_IEN:  bus_rdata[7:0] = ien;
            ADR_STAT: bus_rdata[7:0] = {3'b000, flags[1], 3'b000, flags[0]};
            ADR_CNT:  bus_rdata = cnt;
            ADR_GEN:  bus_rdata = gen;
            default:  bus_rdata = '0;
        endcase
    end

    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt));
    // R4
    clear_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == gen && !pin_reg[3] && mode.clr_src == 3'd1 && !cnt_wr)
        |=> (cnt == '0));
    // R6
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == CNT_MAX && mode.clr_src != 3'd1 && !cnt_wr)
        |=> (cnt == '0 && flags[1]));
    // R12
    bus_cnt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(bus_wdata)));

endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    localparam int V_DIV  [NV] = '{0, 1, 1, 1, 2, 2, 3, 3, 5, 0};
    localparam int V_EDGE [NV] = '{0, 0, 1, 2, 0, 1, 0, 2, 0, 3};
    localparam int V_LEN  [NV] = '{10, 9, 9, 9, 40, 40, 100, 70, 50, 7};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        cap_in = 1'b0;
    logic        cmp_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    tmr_channel dut (
        .clk(clk), .rst(rst), .run(run), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = !clk;

    function automatic int model_ticks(int dv, int ed, int len);
        int n = 0;
        for (int e = 0; e < len; e++) begin
            if (dv == 0) n++;
            else if (dv <= 3) begin
                int div = 1 << (2 * dv);
                int r = e % div;
                bit rs = (r == div / 2 - 1);
                bit fl = (r == div - 1);
                if ((ed == 0 && rs) || (ed == 1 && fl) || (ed >= 2 && (rs || fl))) n++;
            end
        end
        return n;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_stat();
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'd3;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_for(int n);
        @(negedge clk);
        run = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        run = 1'b0;
    endtask

    task automatic clear_flags();
        rd_stat();
        wr(3'd3, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            peek(3'(a), v);
            chk("R1 register reset", v, 16'h0000);
        end
        chk("R1 cmp_out reset", {15'd0, cmp_out}, 16'd0);
        chk("R1 irq reset", {15'd0, irq}, 16'd0);

        // R3: tick schedule table
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, 16'((V_EDGE[i] << 3) | V_DIV[i]));
            wr(3'd4, 16'h0000);
            run_for(V_LEN[i]);
            peek(3'd4, v);
            chk("R3 tick count", v, 16'(model_ticks(V_DIV[i], V_EDGE[i], V_LEN[i])));
        end

        // R2: stopped counter holds
        wr(3'd4, 16'h0321);
        repeat (6) @(negedge clk);
        peek(3'd4, v);
        chk("R2 hold while stopped", v, 16'h0321);

        // R12: read-back of mode and enable registers
        wr(3'd0, 16'h005B);
        peek(3'd0, v);
        chk("R12 mode readback", v, 16'h005B);
        wr(3'd2, 16'h00FF);
        peek(3'd2, v);
        chk("R12 enable keeps bits 0 and 4", v, 16'h0011);

        // R4 R5 R8 R11: clear on match, toggle
        clear_flags();
        wr(3'd5, 16'd4);
        wr(3'd4, 16'd0);
        wr(3'd2, 16'h0001);
        wr(3'd1, 16'h0003);
        chk("R7 code 3 presets low", {15'd0, cmp_out}, 16'd0);
        wr(3'd0, 16'h0020);
        run_for(5);
        peek(3'd4, v);
        chk("R4 counter cleared on match", v, 16'd0);
        peek(3'd3, v);
        chk("R5 event flag on match", v, 16'h0001);
        chk("R8 toggle to high", {15'd0, cmp_out}, 16'd1);
        chk("R11 irq with enable 0", {15'd0, irq}, 16'd1);
        run_for(3);
        peek(3'd4, v);
        chk("R4 count restarts from 0", v, 16'd3);
        run_for(2);
        chk("R8 toggle back low", {15'd0, cmp_out}, 16'd0);

        // R10: flag clear protocol
        wr(3'd3, 16'h0000);
        peek(3'd3, v);
        chk("R10 write 0 without read keeps", v, 16'h0001);
        rd_stat();
        wr(3'd3, 16'h00FF);
        peek(3'd3, v);
        chk("R10 write 1 keeps", v, 16'h0001);
        wr(3'd3, 16'h0000);
        peek(3'd3, v);
        chk("R10 read then write 0 clears", v, 16'h0000);
        chk("R11 irq drops with flag", {15'd0, irq}, 16'd0);

        // R4: clear code 2 never clears
        wr(3'd0, 16'h0040);
        wr(3'd5, 16'd3);
        wr(3'd4, 16'd0);
        run_for(6);
        peek(3'd4, v);
        chk("R4 code 2 no clear", v, 16'd6);

        // R6 R11: wrap
        clear_flags();
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);
        wr(3'd5, 16'h0100);
        wr(3'd2, 16'h0010);
        wr(3'd4, 16'hFFFE);
        run_for(2);
        peek(3'd4, v);
        chk("R6 counter wraps", v, 16'h0000);
        peek(3'd3, v);
        chk("R6 wrap flag", v, 16'h0010);
        chk("R11 irq from wrap", {15'd0, irq}, 16'd1);
        wr(3'd2, 16'h0001);
        chk("R11 wrap masked", {15'd0, irq}, 16'd0);
        clear_flags();

        // R7 R8: pin presets and actions
        wr(3'd0, 16'h0020);
        wr(3'd5, 16'd2);
        wr(3'd4, 16'd0);
        wr(3'd1, 16'h0005);
        chk("R7 code 5 presets high", {15'd0, cmp_out}, 16'd1);
        run_for(3);
        chk("R8 clear on match", {15'd0, cmp_out}, 16'd0);
        wr(3'd1, 16'h0006);
        chk("R7 code 6 presets high", {15'd0, cmp_out}, 16'd1);
        wr(3'd1, 16'h0002);
        chk("R7 code 2 presets low", {15'd0, cmp_out}, 16'd0);
        run_for(3);
        chk("R8 set on match", {15'd0, cmp_out}, 16'd1);
        wr(3'd1, 16'h0000);
        chk("R7 code 0 keeps pin", {15'd0, cmp_out}, 16'd1);
        run_for(3);
        chk("R8 code 0 keeps on match", {15'd0, cmp_out}, 16'd1);

        // R9: capture
        clear_flags();
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0008);
        wr(3'd4, 16'h1234);
        cap_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        peek(3'd5, v);
        chk("R9 no capture before edge k+2", v, 16'd2);
        @(posedge clk);
        @(negedge clk);
        peek(3'd5, v);
        chk("R9 rising capture", v, 16'h1234);
        peek(3'd3, v);
        chk("R9 capture sets flag", v, 16'h0001);
        wr(3'd1, 16'h0009);
        wr(3'd4, 16'h0077);
        cap_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        peek(3'd5, v);
        chk("R9 falling capture", v, 16'h0077);
        wr(3'd4, 16'h0099);
        cap_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        peek(3'd5, v);
        chk("R9 wrong polarity ignored", v, 16'h0077);
        wr(3'd1, 16'h000A);
        wr(3'd4, 16'h00AA);
        cap_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        peek(3'd5, v);
        chk("R9 both edges capture", v, 16'h00AA);

        // R12: bus write wins over tick
        wr(3'd1, 16'h0000);
        wr(3'd5, 16'hF000);
        wr(3'd4, 16'h0000);
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 16'h0100;
        @(negedge clk);
        bus_wr = 1'b0;
        run = 1'b0;
        peek(3'd4, v);
        chk("R12 write wins over tick", v, 16'h0100);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule